// File: doc/BRIEF.md
# A/D Converter Control and Successive-Approximation Sequencer

This block is the digital side of an eight-input, 10-bit successive-approximation A/D converter. A processor reaches it through a byte-wide register port with four addresses. Two of the registers can be written: a control register and a clock-select register. The other two are read-only result bytes. The control register holds the input selection, the port analog/digital configuration, a start bit and an active-low end-of-conversion flag.

A conversion is requested by a two-step handshake on the start bit. Writing the start bit from 0 to 1 aborts any conversion in progress and raises the flag to 1 (busy/not done). Writing it back from 1 to 0 begins a new conversion. The sequencer then runs ten binary-search steps, one on each tick of a programmable prescaler. It presents each trial code to an external DAC/comparator and keeps or drops the trial bit according to the comparator answer. When the tenth step is done, the result is latched, the flag drops to 0 and an interrupt request pulses if interrupts are enabled.

A configuration field of all zeros powers the converter down. Any change of that field re-arms the flag and cancels a running conversion.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset, the control register (address 2) reads 0x40 (flag = 1, all other bits 0). The clock-select register (address 3) and both result bytes read 0x00, and `irq_o` and `adc_pwr_o` are 0.
- R2: A write to address 2 stores the input select in bits [2:0], the configuration in bits [5:3] and the start bit in bit 7. Bit 6 is the flag: write data on bit 6 is ignored, and a read returns the flag there. `chan_o` follows bits [2:0].
- R3: `pcfg_o` follows bits [5:3]. `adc_pwr_o` is 1 exactly when those bits are nonzero.
- R4: A control write that takes the start bit from 0 to 1 sets the flag to 1 in the next cycle, cancels any running conversion, and does not start one.
- R5: A control write that takes the start bit from 1 to 0 starts a conversion when the configuration stays unchanged and nonzero. With configuration zero it starts nothing, and the flag stays 1.
- R6: A conversion makes ten steps, MSB first. `dac_code_o` reads 0x200 in the cycle after the start write. At each step the current trial bit is kept if `cmp_i` = 1 and cleared if `cmp_i` = 0, and then the next lower bit is tried. The flag reads 0 starting 10·N cycles after the start write's clock edge.
- R7: The step period N is 2 system clocks for clock-select bits [1:0] = 00, 8 for 01, and 32 for both 10 and 11.
- R8: Address 1 reads result[9:2]. Address 0 reads {result[1:0], 6'b0}. Writes to addresses 0 and 1 have no effect.
- R9: A write to address 3 stores bits [1:0] and bit 7. Bits [6:2] always read 0. Bit 7 is also driven on `test_o`.
- R10: When `irq_en_i` is 1, `irq_o` is 1 for exactly one cycle: the cycle in which the flag first reads 0 after a conversion. When `irq_en_i` is 0, `irq_o` stays 0.
- R11: A control write that changes bits [5:3] sets the flag to 1 and cancels a running conversion. This takes priority over a start edge in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 result low, 1 result high, 2 control, 3 clock select) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | End-of-conversion interrupt pulse |
| chan_o | output | 3 | Selected analog input to the multiplexer |
| pcfg_o | output | 3 | Port analog/digital configuration |
| adc_pwr_o | output | 1 | Converter power enable |
| test_o | output | 1 | Test-only bit of the clock-select register |
| cmp_i | input | 1 | Comparator answer: 1 when input is at or above the trial code |
| dac_code_o | output | 10 | Trial code for the DAC |

## Verification
The assertions check several rules on every cycle. The flag stays 1 while a conversion runs, and a finished step sequence drops it. An interrupt pulse only follows an un-aborted completion. A powered-down converter is never busy. The prescaler never ticks on two cycles in a row, and the step index stays in range. Only the bench scenarios can show the rest, by comparing against a behavioural model every clock: the exact completion cycle for each prescale setting, that binary search lands on the stub's analog value, the byte split of the result, and the outcome of aborts by a re-issued start or by a configuration change.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ADDR_RES_LO = 2'd0,
    ADDR_RES_HI = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_CKSEL  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    CK_DIV_A = 2'd0,
    CK_DIV_B = 2'd1,
    CK_DIV_C = 2'd2,
    CK_DIV_X = 2'd3
  } ck_sel_e;
endpackage

// File: rtl/adc_clk_prescale.sv
module adc_clk_prescale #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32,
  localparam int MAX_DIV = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                           : ((DIV_B > DIV_C) ? DIV_B : DIV_C),
  localparam int CNT_W = $clog2(MAX_DIV) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  import adc_ctrl_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    case (ck_sel_e'(sel_i))
      CK_DIV_A: lim = CNT_W'(DIV_A - 1);
      CK_DIV_B: lim = CNT_W'(DIV_B - 1);
      default:  lim = CNT_W'(DIV_C - 1);
    endcase
  end

  // >= keeps the counter bounded if the selection shrinks mid-run
  assign tick_o = run_i && !clr_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (tick_o)       cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  p_tick_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int RES_W = 10,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] trial_q;
  logic [RES_W-1:0] mask;
  logic [RES_W-1:0] keep;

  assign mask     = RES_W'(1) << idx_q;
  assign keep     = cmp_i ? trial_q : (trial_q & ~mask);
  assign done_o   = busy_q && tick_i && (idx_q == '0) && !abort_i;
  assign result_o = keep;
  assign busy_o   = busy_q;
  assign trial_o  = trial_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      trial_q <= '0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      idx_q   <= IDX_W'(RES_W - 1);
      trial_q <= RES_W'(1) << (RES_W - 1);
    end else if (busy_q && tick_i) begin
      if (idx_q == '0) begin
        busy_q  <= 1'b0;
        trial_q <= keep;
      end else begin
        trial_q <= keep | (mask >> 1);
        idx_q   <= idx_q - 1'b1;
      end
    end
  end

  p_idx_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (int'(idx_q) < RES_W));
  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs #(
  parameter int RES_W = 10,
  parameter int CH_W  = 3,
  parameter int CFG_W = 3,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32,
  localparam int LO_W = RES_W - 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             irq_en_i,
  output logic             irq_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [CFG_W-1:0] pcfg_o,
  output logic             adc_pwr_o,
  output logic             test_o,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o
);
  import adc_ctrl_pkg::*;

  logic [CH_W-1:0]  chan_q;
  logic [CFG_W-1:0] pcfg_q;
  logic             start_q, eocb_q, test_q, irq_q;
  logic [1:0]       ck_q;
  logic [RES_W-1:0] res_q;

  logic ctrl_we, ck_we, start_rise, start_fall, cfg_chg, cfg_new_on;
  logic sar_start, sar_abort, sar_busy, sar_done, tick;
  logic [RES_W-1:0] sar_res;

  assign ctrl_we    = we_i && (reg_addr_e'(addr_i) == ADDR_CTRL);
  assign ck_we      = we_i && (reg_addr_e'(addr_i) == ADDR_CKSEL);
  assign start_rise = ctrl_we && wdata_i[7] && !start_q;
  assign start_fall = ctrl_we && !wdata_i[7] && start_q;
  assign cfg_chg    = ctrl_we && (wdata_i[CH_W +: CFG_W] != pcfg_q);
  assign cfg_new_on = |wdata_i[CH_W +: CFG_W];
  assign sar_abort  = start_rise || cfg_chg;
  assign sar_start  = start_fall && !cfg_chg && cfg_new_on;

  adc_clk_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sar_start),
    .run_i  (sar_busy),
    .sel_i  (ck_q),
    .tick_o (tick)
  );

  adc_sar_seq #(.RES_W(RES_W)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (sar_start),
    .abort_i  (sar_abort),
    .tick_i   (tick),
    .cmp_i    (cmp_i),
    .busy_o   (sar_busy),
    .done_o   (sar_done),
    .trial_o  (dac_code_o),
    .result_o (sar_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q  <= '0;
      pcfg_q  <= '0;
      start_q <= 1'b0;
      eocb_q  <= 1'b1;
      ck_q    <= '0;
      test_q  <= 1'b0;
      res_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= sar_done && irq_en_i;
      if (ctrl_we) begin
        chan_q  <= wdata_i[CH_W-1:0];
        pcfg_q  <= wdata_i[CH_W +: CFG_W];
        start_q <= wdata_i[7];
      end
      if (ck_we) begin
        ck_q   <= wdata_i[1:0];
        test_q <= wdata_i[7];
      end
      if (sar_abort)     eocb_q <= 1'b1;
      else if (sar_done) eocb_q <= 1'b0;
      if (sar_done)      res_q  <= sar_res;
    end
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      ADDR_RES_LO: rdata_o = {res_q[LO_W-1:0], {(8-LO_W){1'b0}}};
      ADDR_RES_HI: rdata_o = res_q[RES_W-1:LO_W];
      ADDR_CTRL:   rdata_o = {start_q, eocb_q, pcfg_q, chan_q};
      default:     rdata_o = {test_q, 5'b0, ck_q};
    endcase
  end

  assign irq_o     = irq_q;
  assign chan_o    = chan_q;
  assign pcfg_o    = pcfg_q;
  assign adc_pwr_o = |pcfg_q;
  assign test_o    = test_q;

  p_done_clears_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sar_done |=> !eocb_q);
  p_busy_flag_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sar_busy |-> eocb_q);
  p_rise_sets_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rise |=> (eocb_q && !sar_busy));
  p_irq_after_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(sar_done && irq_en_i));
  p_off_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_pwr_o |-> !sar_busy);
endmodule

// File: tb/adc_ctrl_regs_tb_top.sv
module adc_ctrl_regs_tb_top;
  localparam time T = 20ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = 2'd2;
  logic [7:0] wdata_i = 8'h00;
  logic       irq_en_i = 1'b1;
  logic [7:0] rdata_o;
  logic       irq_o, adc_pwr_o, test_o, cmp_i;
  logic [2:0] chan_o, pcfg_o;
  logic [9:0] dac_code_o;

  int checks = 0;
  int errors = 0;
  logic [9:0] vin [8];

  always #(T/2) clk_i = ~clk_i;

  adc_ctrl_regs dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_en_i(irq_en_i), .irq_o(irq_o),
    .chan_o(chan_o), .pcfg_o(pcfg_o), .adc_pwr_o(adc_pwr_o), .test_o(test_o),
    .cmp_i(cmp_i), .dac_code_o(dac_code_o)
  );

  // analog stub: comparator answers 1 while the trial code is at or below the input
  assign cmp_i = (dac_code_o <= vin[chan_o]);

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [2:0] m_chan, m_pcfg;
  logic       m_start, m_eocb, m_test, m_irq, m_busy;
  logic [1:0] m_ck;
  logic [9:0] m_res;
  int         m_rem;

  function automatic int step_n(input logic [1:0] ck);
    return (ck == 2'd0) ? 2 : (ck == 2'd1) ? 8 : 32;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {m_res[1:0], 6'b0};
      2'd1:    return m_res[9:2];
      2'd2:    return {m_start, m_eocb, m_pcfg, m_chan};
      default: return {m_test, 5'b0, m_ck};
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_chan = 0; m_pcfg = 0; m_start = 0; m_eocb = 1; m_test = 0;
      m_irq = 0; m_busy = 0; m_ck = 0; m_res = 0; m_rem = 0;
    end else begin
      bit began;
      began = 0;
      m_irq = 0;
      if (we_i && addr_i == 2'd2) begin
        if ((wdata_i[7] && !m_start) || (wdata_i[5:3] != m_pcfg)) begin
          m_busy = 0; m_eocb = 1;
        end else if (!wdata_i[7] && m_start && wdata_i[5:3] != 0) begin
          m_busy = 1; m_rem = 10 * step_n(m_ck); began = 1;
        end
        m_start = wdata_i[7]; m_pcfg = wdata_i[5:3]; m_chan = wdata_i[2:0];
      end else if (we_i && addr_i == 2'd3) begin
        m_ck = wdata_i[1:0]; m_test = wdata_i[7];
      end
      if (m_busy && !began) begin
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0; m_eocb = 0; m_res = vin[m_chan]; m_irq = irq_en_i;
        end
      end
    end
  end

  // per-cycle comparison, a quarter period after each edge
  always @(posedge clk_i) if (rst_ni) begin
    #(T/4);
    chk(rdata_o, exp_rd(addr_i), (addr_i < 2) ? "R8 model" : (addr_i == 2) ? "R6 model" : "R9 model");
    chk(irq_o, m_irq, "R10 model");
    chk(adc_pwr_o, (m_pcfg != 0), "R3 model");
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 0; addr_i = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk_i); addr_i = a; #1;
    chk(rdata_o, exp, tag);
    @(negedge clk_i); addr_i = 2'd2;
  endtask

  // full conversion on channel ch with pcfg 001 and step period n
  task automatic conv(input logic [2:0] ch, input int n);
    wr(2'd2, {2'b10, 3'b001, ch});
    wr(2'd2, {2'b00, 3'b001, ch});
    #1 chk(dac_code_o, 10'h200, "R6 msb trial");
    cyc(10 * n - 1); #1;
    chk(rdata_o[6], 1, "R7 flag before last step");
    cyc(1); #1;
    chk(rdata_o[6], 0, "R6 R7 flag at completion");
    chk(irq_o, irq_en_i, "R10 pulse");
    cyc(1); #1;
    chk(irq_o, 0, "R10 single cycle");
    rd(2'd1, vin[ch] >> 2, "R8 high byte");
    rd(2'd0, {vin[ch][1:0], 6'b0}, "R8 low byte");
  endtask

  initial begin
    #(T * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vin[0] = 10'h000; vin[1] = 10'h001; vin[2] = 10'h155; vin[3] = 10'h2AA;
    vin[4] = 10'h3FF; vin[5] = 10'h200; vin[6] = 10'h1FF; vin[7] = 10'h0C3;
    cyc(3); rst_ni = 1'b1; cyc(1);

    rd(2'd2, 8'h40, "R1 control"); rd(2'd3, 8'h00, "R1 clksel");
    rd(2'd0, 8'h00, "R1 low");     rd(2'd1, 8'h00, "R1 high");
    chk(adc_pwr_o, 0, "R1 power"); chk(irq_o, 0, "R1 irq");

    wr(2'd2, 8'h0B);
    rd(2'd2, 8'h4B, "R2 readback");
    chk(chan_o, 3, "R2 chan_o"); chk(pcfg_o, 1, "R3 pcfg_o"); chk(adc_pwr_o, 1, "R3 power on");

    conv(3'd3, 2);
    wr(2'd2, 8'h4B);
    rd(2'd2, 8'h0B, "R2 flag bit ignored");
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    rd(2'd1, 8'hAA, "R8 write ignored high");
    rd(2'd0, 8'h80, "R8 write ignored low");

    wr(2'd3, 8'hFD);
    rd(2'd3, 8'h81, "R9 unused bits zero");
    chk(test_o, 1, "R9 test_o");
    conv(3'd4, 8);
    wr(2'd3, 8'h02); conv(3'd0, 32);
    wr(2'd3, 8'h03); conv(3'd6, 32);
    wr(2'd3, 8'h00); conv(3'd7, 2); conv(3'd2, 2);
    irq_en_i = 1'b0; conv(3'd1, 2); irq_en_i = 1'b1;
    conv(3'd5, 2);

    // abort by re-issued start
    wr(2'd2, 8'h8A); wr(2'd2, 8'h0A); cyc(5);
    wr(2'd2, 8'h8A);
    rd(2'd2, 8'hCA, "R4 rise sets flag");
    cyc(40); #1 chk(rdata_o[6], 1, "R4 no completion after abort");
    wr(2'd2, 8'h0A); cyc(20); #1 chk(rdata_o[6], 0, "R5 restart completes");

    // abort by configuration change
    wr(2'd2, 8'h8A); wr(2'd2, 8'h0A); cyc(5);
    wr(2'd2, 8'h12);
    rd(2'd2, 8'h52, "R11 config change");
    cyc(40); #1 chk(rdata_o[6], 1, "R11 no completion");

    // powered down: handshake starts nothing
    wr(2'd2, 8'h05);
    chk(adc_pwr_o, 0, "R3 power off");
    wr(2'd2, 8'h85); wr(2'd2, 8'h05); cyc(40);
    rd(2'd2, 8'h45, "R5 no conversion when off");
    chk(irq_o, 0, "R10 no irq when off");

    cyc(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule